// File: doc/BRIEF.md
# Fast-Page-Mode DRAM Device Model

This block is a clock-sampled, synthesizable stand-in for the device side of a 256K x 16 fast-page DRAM. It is meant to sit on the far side of a memory controller under test. Every clock it samples the row strobe, two byte-lane column strobes, write enable, output enable, a 9-bit multiplexed address and a 16-bit write bus. From those samples it decides which kind of cycle is running: a normal access, a row-only refresh, or a refresh where a column strobe is already low when the row strobe falls.

Access cycles latch a row and then one column per column-strobe fall. Stores are byte-masked into a small array indexed by the low address bits. Read data comes back on a separate bus with one drive-enable bit per byte lane, so the controller side can model the tristate bus. An internal 9-bit refresh counter supplies the row for strobe-first refreshes.

The model also watches protocol rules. It raises one sticky error bit when a read or write happens before enough warm-up row cycles have completed. It raises a second sticky error bit when any of the 512 rows has not been refreshed within a refresh window.

Top module: `fpm_dram_model`

## Requirements
- R1: The internal column strobe is active from the first fall of either byte strobe until both byte strobes are high. A second byte strobe falling while the first is still low does not latch a new column.
- R2: The row is latched when the row strobe falls and the column when the internal column strobe falls. The cell array is selected by the low ARR_ROW_W row bits and the low ARR_COL_W column bits.
- R3: If either byte strobe is low when the row strobe falls, the cycle is a counter refresh. The address is ignored, no cell is written even when write enable goes low, and both lanes stay undriven.
- R4: A store happens when the later of "internal column strobe low" and "write enable low" occurs in an access cycle. The store takes the write bus at that moment and writes byte lane 0 (bits 7:0) only if the lower strobe is low, and lane 1 (bits 15:8) only if the upper strobe is low.
- R5: In an access cycle with write enable high, lane_drv[0] is 1 exactly while the lower strobe and output enable are both low, and lane_drv[1] likewise with the upper strobe. Each output lies one clock behind the sampled inputs. A lane that is not driven reads back 0.
- R6: During a row-only refresh (both byte strobes high) and in standby (row strobe high), lane_drv is 0 whatever output enable and the byte strobes do.
- R7: While the row strobe stays low, each new internal column strobe fall latches a new column, so a burst of reads or writes can walk one row.
- R8: The refresh counter advances by one per counter refresh and wraps from 511 to 0.
- R9: proto_err[0] becomes 1, and stays 1 until reset, if a read or store starts before WARM_CYCLES row cycles (row strobe rising edges) have completed since reset.
- R10: proto_err[1] becomes 1, and stays 1 until reset, when a REF_WINDOW-clock window closes without every one of the 512 rows having been refreshed by any row-strobe cycle in it.
- R11: After reset, lane_drv, rdata and proto_err are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| row_stb_n | input | 1 | Row strobe, active low |
| col_hi_n | input | 1 | Upper byte column strobe, active low |
| col_lo_n | input | 1 | Lower byte column strobe, active low |
| wr_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 9 | Multiplexed row/column address |
| wdata | input | 16 | Write data bus |
| rdata | output | 16 | Read data; undriven lanes read 0 |
| lane_drv | output | 2 | Per-lane drive enable: bit 0 = bits 7:0, bit 1 = bits 15:8 |
| proto_err | output | 2 | Sticky errors: bit 0 early access, bit 1 missed refresh |

## Verification
The assertions assume that the strobes are clean levels at each sampling edge. They also assume that the row strobe and a column strobe never fall on the same edge, because that would make the cycle kind ambiguous. The stimulus changes every input only on the falling clock edge. It always moves the column strobes at least one clock before or after a row-strobe edge. Each byte lane's output is checked one clock after the inputs that enable it, which matches the single sampling register. The refresh checks wait for the window boundaries, counted in clocks since reset, before they read the sticky error bit.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
   typedef enum logic [1:0] {
      CYC_IDLE    = 2'd0,
      CYC_ACCESS  = 2'd1,
      CYC_REFRESH = 2'd2
   } cyc_kind_t;
endpackage

// File: rtl/fpm_strobe_decode.sv
module fpm_strobe_decode
   import fpm_pkg::*;
#(
   parameter int ADDR_W    = 9,
   parameter int ARR_ROW_W = 3,
   parameter int ARR_COL_W = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 row_stb_n,
   input  logic                 col_hi_n,
   input  logic                 col_lo_n,
   input  logic                 wr_n,
   input  logic                 oe_n,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [ADDR_W-1:0]    ref_cnt,
   output logic [ARR_ROW_W-1:0] row_q,
   output logic [ARR_COL_W-1:0] col_q,
   output logic [ARR_COL_W-1:0] col_eff,
   output logic                 wr_start,
   output logic [1:0]           wr_lanes,
   output logic                 acc_start,
   output logic [1:0]           lane_drv,
   output logic                 ref_pulse,
   output logic                 cbr_pulse,
   output logic [ADDR_W-1:0]    ref_row,
   output logic                 row_done
);
   logic      p_row, p_hi, p_lo, p_wr, p_oe;
   logic      wr_q, rd_q;
   cyc_kind_t kind;
   logic      cas_now, cas_was, row_fall, row_rise, cas_fall;
   logic      in_access, wr_cond, rd_cond, live;

   always_comb begin
      cas_now   = !(col_hi_n && col_lo_n);
      cas_was   = !(p_hi && p_lo);
      row_fall  = p_row && !row_stb_n;
      row_rise  = !p_row && row_stb_n;
      cas_fall  = cas_now && !cas_was;
      in_access = (kind == CYC_ACCESS) && !row_stb_n;
      wr_cond   = in_access && cas_now && !wr_n;
      rd_cond   = in_access && cas_now && wr_n && !oe_n;
      wr_start  = wr_cond && !wr_q;
      acc_start = wr_start || (rd_cond && !rd_q);
      wr_lanes  = {!col_hi_n, !col_lo_n};
      col_eff   = cas_fall ? addr[ARR_COL_W-1:0] : col_q;
      ref_pulse = row_fall;
      cbr_pulse = row_fall && cas_now;
      ref_row   = cas_now ? ref_cnt : addr;
      row_done  = row_rise;
      live      = (kind == CYC_ACCESS) && !p_row && p_wr && !p_oe;
      lane_drv  = {live && !p_hi, live && !p_lo};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         p_row <= 1'b1;
         p_hi  <= 1'b1;
         p_lo  <= 1'b1;
         p_wr  <= 1'b1;
         p_oe  <= 1'b1;
         wr_q  <= 1'b0;
         rd_q  <= 1'b0;
         kind  <= CYC_IDLE;
         row_q <= '0;
         col_q <= '0;
      end else begin
         p_row <= row_stb_n;
         p_hi  <= col_hi_n;
         p_lo  <= col_lo_n;
         p_wr  <= wr_n;
         p_oe  <= oe_n;
         wr_q  <= wr_cond;
         rd_q  <= rd_cond;
         if (row_fall) begin
            kind <= cas_now ? CYC_REFRESH : CYC_ACCESS;
            if (!cas_now) row_q <= addr[ARR_ROW_W-1:0];
         end else if (row_rise) begin
            kind <= CYC_IDLE;
         end
         if (cas_fall && in_access) col_q <= addr[ARR_COL_W-1:0];
      end
   end

   AST_COL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (cas_now && cas_was) |=> $stable(col_q));                     // R1
   AST_CBR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      cbr_pulse |=> (lane_drv == 2'b00));                           // R3
endmodule

// File: rtl/fpm_cell_array.sv
module fpm_cell_array #(
   parameter int ARR_ROW_W = 3,
   parameter int ARR_COL_W = 3,
   parameter int DATA_W    = 16
) (
   input  logic                 clk,
   input  logic                 wr_en,
   input  logic [1:0]           wr_lanes,
   input  logic [ARR_ROW_W-1:0] wr_row,
   input  logic [ARR_COL_W-1:0] wr_col,
   input  logic [DATA_W-1:0]    wdata,
   input  logic [ARR_ROW_W-1:0] rd_row,
   input  logic [ARR_COL_W-1:0] rd_col,
   output logic [DATA_W-1:0]    rdata
);
   localparam int LANES  = 2;
   localparam int LANE_W = DATA_W / LANES;
   localparam int IDX_W  = ARR_ROW_W + ARR_COL_W;
   localparam int DEPTH  = 1 << IDX_W;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] cells [DEPTH];
      always_ff @(posedge clk) begin
         if (wr_en && wr_lanes[g])
            cells[{wr_row, wr_col}] <= wdata[g*LANE_W +: LANE_W];
      end
      assign rdata[g*LANE_W +: LANE_W] = cells[{rd_row, rd_col}];
   end
endmodule

// File: rtl/fpm_refresh_monitor.sv
module fpm_refresh_monitor #(
   parameter int ADDR_W      = 9,
   parameter int REF_WINDOW  = 8192,
   parameter int WARM_CYCLES = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ref_pulse,
   input  logic              cbr_pulse,
   input  logic [ADDR_W-1:0] ref_row,
   input  logic              row_done,
   input  logic              acc_start,
   output logic [ADDR_W-1:0] ref_cnt,
   output logic [1:0]        err
);
   localparam int NUM_ROWS = 1 << ADDR_W;
   localparam int WIN_W    = $clog2(REF_WINDOW);
   localparam int WARM_W   = $clog2(WARM_CYCLES + 1);

   logic [NUM_ROWS-1:0] seen, seen_nx;
   logic [WIN_W-1:0]    win;
   logic [WARM_W-1:0]   warm;
   logic                win_last, warm_ok;

   always_comb begin
      seen_nx = seen;
      if (ref_pulse) seen_nx[ref_row] = 1'b1;
      win_last = (win == WIN_W'(REF_WINDOW - 1));
      warm_ok  = (warm == WARM_W'(WARM_CYCLES));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ref_cnt <= '0;
         seen    <= '0;
         win     <= '0;
         warm    <= '0;
         err     <= 2'b00;
      end else begin
         if (cbr_pulse) ref_cnt <= ref_cnt + 1'b1;
         if (row_done && !warm_ok) warm <= warm + 1'b1;
         if (acc_start && !warm_ok) err[0] <= 1'b1;
         if (win_last) begin
            win  <= '0;
            seen <= '0;
            if (!(&seen_nx)) err[1] <= 1'b1;
         end else begin
            win  <= win + 1'b1;
            seen <= seen_nx;
         end
      end
   end

   AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !cbr_pulse |=> $stable(ref_cnt));                             // R8
   AST_EARLY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      err[0] |=> err[0]);                                           // R9
   AST_REF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      err[1] |=> err[1]);                                           // R10
endmodule

// File: rtl/fpm_dram_model.sv
module fpm_dram_model #(
   parameter int ADDR_W      = 9,
   parameter int DATA_W      = 16,
   parameter int ARR_ROW_W   = 3,
   parameter int ARR_COL_W   = 3,
   parameter int REF_WINDOW  = 8192,
   parameter int WARM_CYCLES = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              row_stb_n,
   input  logic              col_hi_n,
   input  logic              col_lo_n,
   input  logic              wr_n,
   input  logic              oe_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic [1:0]        lane_drv,
   output logic [1:0]        proto_err
);
   localparam int LANE_W = DATA_W / 2;

   if (DATA_W != 16) begin : g_bad_data
      $error("fpm_dram_model: DATA_W must be 16 (two byte lanes)");
   end
   if (ARR_ROW_W > ADDR_W || ARR_COL_W > ADDR_W || ARR_ROW_W < 1 || ARR_COL_W < 1) begin : g_bad_arr
      $error("fpm_dram_model: array index widths must lie in 1..ADDR_W");
   end
   if (REF_WINDOW < 2 || WARM_CYCLES < 1) begin : g_bad_win
      $error("fpm_dram_model: REF_WINDOW >= 2 and WARM_CYCLES >= 1 required");
   end

   logic [ARR_ROW_W-1:0] row_q;
   logic [ARR_COL_W-1:0] col_q, col_eff;
   logic                 wr_start, acc_start, ref_pulse, cbr_pulse, row_done;
   logic [1:0]           wr_lanes;
   logic [ADDR_W-1:0]    ref_cnt, ref_row;
   logic [DATA_W-1:0]    arr_q;

   fpm_strobe_decode #(
      .ADDR_W(ADDR_W), .ARR_ROW_W(ARR_ROW_W), .ARR_COL_W(ARR_COL_W)
   ) u_dec (
      .clk(clk), .rst_n(rst_n), .row_stb_n(row_stb_n), .col_hi_n(col_hi_n),
      .col_lo_n(col_lo_n), .wr_n(wr_n), .oe_n(oe_n), .addr(addr),
      .ref_cnt(ref_cnt), .row_q(row_q), .col_q(col_q), .col_eff(col_eff),
      .wr_start(wr_start), .wr_lanes(wr_lanes), .acc_start(acc_start),
      .lane_drv(lane_drv), .ref_pulse(ref_pulse), .cbr_pulse(cbr_pulse),
      .ref_row(ref_row), .row_done(row_done)
   );

   fpm_cell_array #(
      .ARR_ROW_W(ARR_ROW_W), .ARR_COL_W(ARR_COL_W), .DATA_W(DATA_W)
   ) u_arr (
      .clk(clk), .wr_en(wr_start), .wr_lanes(wr_lanes), .wr_row(row_q),
      .wr_col(col_eff), .wdata(wdata), .rd_row(row_q), .rd_col(col_q),
      .rdata(arr_q)
   );

   fpm_refresh_monitor #(
      .ADDR_W(ADDR_W), .REF_WINDOW(REF_WINDOW), .WARM_CYCLES(WARM_CYCLES)
   ) u_mon (
      .clk(clk), .rst_n(rst_n), .ref_pulse(ref_pulse), .cbr_pulse(cbr_pulse),
      .ref_row(ref_row), .row_done(row_done), .acc_start(acc_start),
      .ref_cnt(ref_cnt), .err(proto_err)
   );

   always_comb begin
      rdata[LANE_W-1:0]      = lane_drv[0] ? arr_q[LANE_W-1:0]      : '0;
      rdata[DATA_W-1:LANE_W] = lane_drv[1] ? arr_q[DATA_W-1:LANE_W] : '0;
   end

   AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      $past(row_stb_n) |-> (lane_drv == 2'b00));                    // R6
   AST_LO_LANE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      lane_drv[0] |-> $past(!col_lo_n && !oe_n && wr_n));           // R5
   AST_HI_LANE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      lane_drv[1] |-> $past(!col_hi_n && !oe_n && wr_n));           // R5
   AST_RESET_QUIET: assert property (@(posedge clk)
      $past(!rst_n) |-> (lane_drv == 2'b00 && proto_err == 2'b00)); // R11
endmodule

// File: tb/sim_fpm_dram_model.sv
module sim_fpm_dram_model;
   localparam int CLK_PERIOD = 10;
   localparam int WIN        = 8192;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        row_n = 1'b1, hi_n = 1'b1, lo_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
   logic [8:0]  addr = '0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic [1:0]  drv, err;
   int          n_cmp = 0, n_bad = 0, cyc = 0;
   logic [15:0] model [64];

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

   fpm_dram_model u0 (
      .clk(clk), .rst_n(rst_n), .row_stb_n(row_n), .col_hi_n(hi_n),
      .col_lo_n(lo_n), .wr_n(we_n), .oe_n(oe_n), .addr(addr), .wdata(wdata),
      .rdata(rdata), .lane_drv(drv), .proto_err(err)
   );

   function automatic logic [15:0] pat(int r, int c);
      return 16'(((r * 8 + c) * 16'h0409) ^ 16'hC35A);
   endfunction

   task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   task automatic step(); @(negedge clk); endtask

   task automatic ras_only(int r);
      addr = 9'(r); row_n = 1'b0; step();
      row_n = 1'b1; step();
   endtask

   task automatic cbr();
      lo_n = 1'b0; hi_n = 1'b0; step();
      row_n = 1'b0; step();
      row_n = 1'b1; lo_n = 1'b1; hi_n = 1'b1; step();
   endtask

   task automatic open_row(int r); addr = 9'(r); row_n = 1'b0; step(); endtask
   task automatic close_row(); row_n = 1'b1; step(); endtask

   // mask bit 0 = lower strobe, bit 1 = upper strobe
   task automatic write_col(int r, int c, logic [15:0] d, logic [1:0] m);
      addr = 9'(c); wdata = d; we_n = 1'b0; lo_n = !m[0]; hi_n = !m[1]; step();
      lo_n = 1'b1; hi_n = 1'b1; we_n = 1'b1; step();
      if (m[0]) model[(r%8)*8 + c%8][7:0]  = d[7:0];
      if (m[1]) model[(r%8)*8 + c%8][15:8] = d[15:8];
   endtask

   task automatic read_col(string tag, int r, int c);
      addr = 9'(c); lo_n = 1'b0; hi_n = 1'b0; oe_n = 1'b0; step();
      chk({tag, " drv"}, {14'd0, drv}, 16'd3);
      chk({tag, " data"}, rdata, model[(r%8)*8 + c%8]);
      lo_n = 1'b1; hi_n = 1'b1; oe_n = 1'b1; step();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      repeat (3) step();
      rst_n = 1'b1; step();
      chk("R11 reset drv", {14'd0, drv}, 16'd0);
      chk("R11 reset rdata", rdata, 16'd0);
      chk("R11 reset err", {14'd0, err}, 16'd0);

      // R9 boundary: access in the 8th row cycle is still early
      for (int i = 0; i < 7; i++) ras_only(i);
      open_row(0); write_col(0, 0, 16'h0000, 2'b11); close_row();
      chk("R9 early access flagged", {14'd0, err}, 16'd1);

      rst_n = 1'b0; step(); step(); rst_n = 1'b1; step();
      chk("R11 err cleared by reset", {14'd0, err}, 16'd0);
      for (int i = 0; i < 8; i++) ras_only(i + 8);
      for (int i = 0; i < 512; i++) cbr();

      // R7 page-mode write sweep, R2 then read sweep
      for (int r = 0; r < 8; r++) begin
         open_row(r);
         for (int c = 0; c < 8; c++) write_col(r, c, pat(r, c), 2'b11);
         close_row();
      end
      chk("R9 no error after warm-up", {14'd0, err}, 16'd0);
      for (int r = 0; r < 8; r++) begin
         open_row(r);
         for (int c = 0; c < 8; c++) read_col("R7 page read", r, c);
         close_row();
      end
      open_row(9'd200); read_col("R2 low row/col bits select", 200, 17); close_row();

      // R4 byte-masked stores
      open_row(2);
      for (int c = 0; c < 8; c++) write_col(2, c, ~pat(2, c), 2'b01);
      close_row();
      open_row(3);
      for (int c = 0; c < 8; c++) write_col(3, c, 16'h1111 * 16'(c), 2'b10);
      close_row();
      for (int r = 2; r < 4; r++) begin
         open_row(r);
         for (int c = 0; c < 8; c++) read_col("R4 byte lanes", r, c);
         close_row();
      end

      // R4 late write: strobe first, write enable later
      open_row(4);
      addr = 9'd5; lo_n = 1'b0; hi_n = 1'b0; step();
      chk("R5 no drive with oe high", {14'd0, drv}, 16'd0);
      we_n = 1'b0; wdata = 16'h1234; step();
      lo_n = 1'b1; hi_n = 1'b1; we_n = 1'b1; step();
      model[4*8+5] = 16'h1234;
      read_col("R4 late write", 4, 5);
      // R5 output enable falls after the strobe
      addr = 9'd6; lo_n = 1'b0; hi_n = 1'b0; step();
      chk("R5 strobe alone no drive", {14'd0, drv}, 16'd0);
      oe_n = 1'b0; step();
      chk("R5 drive after oe", {14'd0, drv}, 16'd3);
      chk("R5 data after oe", rdata, model[4*8+6]);
      lo_n = 1'b1; hi_n = 1'b1; oe_n = 1'b1; step();
      close_row();

      // R1 merged strobe: column from first fall only
      open_row(5);
      addr = 9'd2; lo_n = 1'b0; oe_n = 1'b0; step();
      chk("R1 lo lane only", {14'd0, drv}, 16'd1);
      chk("R1 lo data", rdata, model[42] & 16'h00FF);
      addr = 9'd7; hi_n = 1'b0; step();
      chk("R1 both lanes", {14'd0, drv}, 16'd3);
      chk("R1 column kept", rdata, model[42]);
      lo_n = 1'b1; step();
      chk("R1 hi lane only", {14'd0, drv}, 16'd2);
      chk("R1 hi data", rdata, model[42] & 16'hFF00);
      hi_n = 1'b1; oe_n = 1'b1; step();
      close_row();

      // R6 row-only refresh and standby
      addr = 9'd3; oe_n = 1'b0; row_n = 1'b0; step();
      chk("R6 row-only no drive", {14'd0, drv}, 16'd0);
      row_n = 1'b1; lo_n = 1'b0; hi_n = 1'b0; step();
      chk("R6 standby no drive", {14'd0, drv}, 16'd0);
      lo_n = 1'b1; hi_n = 1'b1; oe_n = 1'b1; step();

      // R3 counter refresh ignores address, write and output enable
      lo_n = 1'b0; hi_n = 1'b0; oe_n = 1'b0; addr = 9'd0; step();
      row_n = 1'b0; step();
      chk("R3 no drive in refresh", {14'd0, drv}, 16'd0);
      we_n = 1'b0; wdata = 16'hFFFF; step();
      chk("R3 still no drive", {14'd0, drv}, 16'd0);
      row_n = 1'b1; lo_n = 1'b1; hi_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; step();
      open_row(0); read_col("R3 cell 0 unchanged", 0, 0); close_row();
      open_row(3); read_col("R3 cell 3 unchanged", 3, 0); close_row();

      // R10 first window fully refreshed
      while (cyc < WIN + 40) step();
      chk("R10 window 1 clean", {14'd0, err}, 16'd0);
      // R8 second window: 512 more counter refreshes must cover all rows
      for (int i = 0; i < 512; i++) cbr();
      while (cyc < 2 * WIN + 40) step();
      chk("R8 counter wraps, window 2 clean", {14'd0, err}, 16'd0);
      while (cyc < 3 * WIN + 40) step();
      chk("R10 missed refresh flagged", {14'd0, err}, 16'd2);
      summary();
   end
endmodule